// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block performs address translation after a translation cache has missed. It takes a 32-bit virtual address, reads the first-level page table entry from memory, uses that entry to find the second-level table, reads the leaf entry, and returns either a physical address with its access flags or a page-fault indication. Pages are 4 KB, so the low 12 bits of the virtual address pass through untranslated. Every entry is 4 bytes wide. The address of an entry is the table base plus the index times the entry size.

The virtual address is split into a 10-bit first-level index (bits 31:22), a 10-bit second-level index (bits 21:12) and a 12-bit offset. An entry carries a valid flag in bit 0, read/write/execute in bits 1 to 3, user in bit 4, dirty in bit 5, referenced in bit 6, and a frame number in bits 31:12. The frame number is either the next table's base or the final physical frame. One root table register is held per running program. Software rewrites it on a context switch through a write strobe. A rewrite that arrives mid-walk is parked and applied once the walker is idle again. At most one memory read is outstanding at any time.

Top module: `xlat_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_req_valid is 0, and the root frame number is 0.
- R2: The first memory read of a walk is at address {root_ppn, 12'h000} + vaddr[31:22]*4, with bits 1:0 zero.
- R3: The second read is at {L1 entry[31:12], 12'h000} + vaddr[21:12]*4. Bits 11:1 of the first-level entry have no effect.
- R4: On a valid leaf, rsp_fault is 0, rsp_paddr is {leaf[31:12], vaddr[11:0]}, and rsp_flags is leaf[6:1] (flag bit 0 read, 1 write, 2 execute, 3 user, 4 dirty, 5 referenced).
- R5: A first-level entry with bit 0 clear gives rsp_fault=1 and rsp_fault_lvl=0 after exactly one memory read, with rsp_paddr and rsp_flags at zero.
- R6: A leaf with bit 0 clear gives rsp_fault=1 and rsp_fault_lvl=1 after exactly two memory reads, with rsp_paddr and rsp_flags at zero.
- R7: Only one memory read is outstanding at a time. While mem_req_ready is low, mem_req_valid stays high and mem_req_addr stays unchanged.
- R8: rsp_valid is a one-cycle pulse. With memory latency L cycles, it appears 5+2L clock edges after acceptance for a two-read walk, and 3+L edges after acceptance for a first-level fault.
- R9: req_ready is low from the edge that accepts a request until the walker has returned to idle.
- R10: A root write while a walk is in progress does not affect that walk, and takes effect for the next walk.
- R11: A root write made while idle takes effect for the next accepted walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_wr_en | input | 1 | Strobe to load a new root table frame number |
| root_wr_ppn | input | 20 | Root table frame number to load |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Result is a page fault |
| rsp_fault_lvl | output | 1 | Level of the invalid entry: 0 first, 1 second |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_flags | output | 6 | Access flags of the leaf entry |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
Each read adds the memory model's latency L on top of a fixed internal cost. A full walk or a leaf fault therefore reports 5+2L edges after the accepting edge, and a first-level fault reports 3+L edges after it. The bench counts edges from acceptance and samples the outputs on falling edges. It compares the count with these formulas for latencies 0 through 3 and records every read address in issue order. The stall case and the mid-walk root write have concurrent branches. These branches probe the held read and req_ready at chosen falling edges before the result is due.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_L1_REQ  = 3'd1,
    ST_L1_WAIT = 3'd2,
    ST_L2_REQ  = 3'd3,
    ST_L2_WAIT = 3'd4,
    ST_DONE    = 3'd5,
    ST_FAULT   = 3'd6
  } walk_st_e;

  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_FLAG_LSB  = 1;
  localparam int FLAG_W        = 6;
endpackage

// File: rtl/xw_root_reg.sv
module xw_root_reg #(
  parameter int PPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             wr_en,
  input  logic [PPN_W-1:0] wr_ppn,
  output logic [PPN_W-1:0] root_ppn
);
  logic [PPN_W-1:0] base_q, base_d, pend_q;
  logic             pend_v_q, pend_v_d;
  logic             base_en, pend_en;

  always_comb begin
    base_en  = idle & (wr_en | pend_v_q);
    base_d   = wr_en ? wr_ppn : pend_q;
    pend_en  = wr_en & ~idle;
    if (pend_en)   pend_v_d = 1'b1;
    else if (idle) pend_v_d = 1'b0;
    else           pend_v_d = pend_v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      if (base_en) base_q <= base_d;
      if (pend_en) pend_q <= wr_ppn;
      pend_v_q <= pend_v_d;
    end
  end

  assign root_ppn = base_q;

  // R10: the root value never moves while a walk is in flight
  p_root_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> (root_ppn == $past(root_ppn)));

  // R11: an idle write is visible on the following cycle
  p_idle_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && wr_en) |=> (root_ppn == $past(wr_ppn)));
endmodule

// File: rtl/xw_pte_addr.sv
module xw_pte_addr #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int LEVELS    = 2,
  parameter int PTE_BYTES = 4,
  localparam int IDX_W    = (VA_W - OFF_W) / LEVELS,
  localparam int PPN_W    = PA_W - OFF_W,
  localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int SH       = $clog2(PTE_BYTES)
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic [PPN_W-1:0] next_ppn,
  output logic [PA_W-1:0]  pte_addr
);
  logic [IDX_W-1:0] idx [LEVELS];
  logic [PPN_W-1:0] tbl;
  logic [IDX_W-1:0] sel;

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx[l] = vaddr[OFF_W + (LEVELS-1-l)*IDX_W +: IDX_W];
  end

  always_comb begin
    tbl      = (lvl == '0) ? root_ppn : next_ppn;
    sel      = idx[lvl];
    pte_addr = {tbl, {OFF_W{1'b0}}} + (PA_W'(sel) << SH);
  end
endmodule

// File: rtl/xw_walk_fsm.sv
module xw_walk_fsm
  import xw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic [VA_W-1:0]   vaddr_q,
  output logic              lvl,
  output logic              idle,
  output logic [PPN_W-1:0]  next_ppn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [PA_W-1:0]   mem_rsp_data,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_fault_lvl,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [FLAG_W-1:0] rsp_flags
);
  walk_st_e          st_q, st_d;
  logic              acc_en, next_en, leaf_en, flt_en;
  logic [PPN_W-1:0]  next_q, leaf_ppn_q;
  logic [FLAG_W-1:0] leaf_flg_q;
  logic              flt_lvl_q;
  logic              pte_ok;
  logic              out_q;

  assign pte_ok = mem_rsp_data[PTE_VALID_BIT];

  always_comb begin
    st_d    = st_q;
    acc_en  = 1'b0;
    next_en = 1'b0;
    leaf_en = 1'b0;
    flt_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d   = ST_L1_REQ;
        acc_en = 1'b1;
      end
      ST_L1_REQ: if (mem_req_ready) st_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rsp_valid) begin
        if (pte_ok) begin
          st_d    = ST_L2_REQ;
          next_en = 1'b1;
        end else begin
          st_d   = ST_FAULT;
          flt_en = 1'b1;
        end
      end
      ST_L2_REQ: if (mem_req_ready) st_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rsp_valid) begin
        if (pte_ok) begin
          st_d    = ST_DONE;
          leaf_en = 1'b1;
        end else begin
          st_d   = ST_FAULT;
          flt_en = 1'b1;
        end
      end
      ST_DONE:  st_d = ST_IDLE;
      ST_FAULT: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      vaddr_q    <= '0;
      next_q     <= '0;
      leaf_ppn_q <= '0;
      leaf_flg_q <= '0;
      flt_lvl_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (acc_en)  vaddr_q <= req_vaddr;
      if (next_en) next_q  <= mem_rsp_data[PA_W-1:OFF_W];
      if (leaf_en) begin
        leaf_ppn_q <= mem_rsp_data[PA_W-1:OFF_W];
        leaf_flg_q <= mem_rsp_data[PTE_FLAG_LSB +: FLAG_W];
      end
      if (flt_en) flt_lvl_q <= (st_q == ST_L2_WAIT);
    end
  end

  always_comb begin
    idle          = (st_q == ST_IDLE);
    req_ready     = idle;
    lvl           = (st_q == ST_L2_REQ) || (st_q == ST_L2_WAIT);
    next_ppn      = next_q;
    mem_req_valid = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
    rsp_valid     = (st_q == ST_DONE) || (st_q == ST_FAULT);
    rsp_fault     = (st_q == ST_FAULT);
    rsp_fault_lvl = (st_q == ST_FAULT) ? flt_lvl_q : 1'b0;
    rsp_paddr     = (st_q == ST_DONE) ? {leaf_ppn_q, vaddr_q[OFF_W-1:0]} : '0;
    rsp_flags     = (st_q == ST_DONE) ? leaf_flg_q : '0;
  end

  // outstanding-read tracker used only by the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) out_q <= 1'b1;
    else if (mem_rsp_valid) out_q <= 1'b0;
  end

  p_single_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> !mem_req_valid);

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_fault_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_flags == '0));
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int OFF_W       = 12,
  parameter int PTE_BYTES   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PPN_W      = PA_W - OFF_W,
  localparam int SH         = $clog2(PTE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_wr_en,
  input  logic [PPN_W-1:0]  root_wr_ppn,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_fault_lvl,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [FLAG_W-1:0] rsp_flags,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PA_W-1:0]   mem_rsp_data
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_ni;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_rst
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_pipe[s] <= 1'b0;
      else        rst_pipe[s] <= (s == 0) ? 1'b1 : rst_pipe[(s == 0) ? 0 : s-1];
    end
  end
  assign rst_ni = rst_pipe[SYNC_STAGES-1];

  logic [VA_W-1:0]  vaddr_q;
  logic             lvl, idle;
  logic [PPN_W-1:0] root_ppn, next_ppn;

  xw_root_reg #(.PPN_W(PPN_W)) u_root (
    .clk      (clk),
    .rst_n    (rst_ni),
    .idle     (idle),
    .wr_en    (root_wr_en),
    .wr_ppn   (root_wr_ppn),
    .root_ppn (root_ppn)
  );

  xw_pte_addr #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .LEVELS(2), .PTE_BYTES(PTE_BYTES)
  ) u_addr (
    .vaddr    (vaddr_q),
    .lvl      (lvl),
    .root_ppn (root_ppn),
    .next_ppn (next_ppn),
    .pte_addr (mem_req_addr)
  );

  xw_walk_fsm #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_ni),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .vaddr_q       (vaddr_q),
    .lvl           (lvl),
    .idle          (idle),
    .next_ppn      (next_ppn),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl),
    .rsp_paddr     (rsp_paddr),
    .rsp_flags     (rsp_flags)
  );

  p_entry_aligned_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req_valid |-> (mem_req_addr[SH-1:0] == '0));

  p_read_held_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [31:0] va;
    logic        flt;
    logic        flv;
    logic [31:0] pa;
    logic [5:0]  fl;
    logic [31:0] a1;
    logic [31:0] a2;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{32'h0040_3456, 1'b0, 1'b0, 32'hABCD_E456, 6'h27, 32'h0010_0004, 32'h0020_000C, 2'd0},
    '{32'h0040_3456, 1'b0, 1'b0, 32'hABCD_E456, 6'h27, 32'h0010_0004, 32'h0020_000C, 2'd2},
    '{32'h0040_4123, 1'b1, 1'b1, 32'h0,         6'h00, 32'h0010_0004, 32'h0020_0010, 2'd0},
    '{32'h0080_0FFF, 1'b1, 1'b0, 32'h0,         6'h00, 32'h0010_0008, 32'h0,         2'd1},
    '{32'hFFFF_FABC, 1'b0, 1'b0, 32'h1234_5ABC, 6'h3F, 32'h0010_0FFC, 32'h0030_0FFC, 2'd0},
    '{32'h0040_0000, 1'b0, 1'b0, 32'h0000_0000, 6'h08, 32'h0010_0004, 32'h0020_0000, 2'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_wr_en = 1'b0;
  logic [19:0] root_wr_ppn = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid, rsp_fault, rsp_fault_lvl;
  logic [31:0] rsp_paddr;
  logic [5:0]  rsp_flags;
  logic        mem_req_valid;
  logic        mem_rdy = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_NS/2) clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk(clk), .rst_n(rst_n),
    .root_wr_en(root_wr_en), .root_wr_ppn(root_wr_ppn),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
    .rsp_paddr(rsp_paddr), .rsp_flags(rsp_flags),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_rdy), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // memory model
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rlog [4];
  int          nlog = 0;
  int          lat = 0;
  int          cnt = 0;
  logic        busy = 1'b0;
  logic [31:0] raddr = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (busy) begin
      if (cnt <= 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= rd(raddr);
        busy <= 1'b0;
      end else cnt <= cnt - 1;
    end
    if (mem_req_valid && mem_rdy) begin
      if (nlog < 4) rlog[nlog] <= mem_req_addr;
      nlog <= nlog + 1;
      if (lat == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= rd(mem_req_addr);
      end else begin
        busy  <= 1'b1;
        cnt   <= lat;
        raddr <= mem_req_addr;
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, output logic f, output logic fv,
                      output logic [31:0] pa, output logic [5:0] fl, output int n);
    @(negedge clk);
    chk({31'b0, req_ready}, 32'd1, "R9 walker idle before request");
    nlog = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && n < 300) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    f = rsp_fault; fv = rsp_fault_lvl; pa = rsp_paddr; fl = rsp_flags;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic f, fv;
    logic [31:0] pa;
    logic [5:0]  fl;
    int n;

    mem[32'h0010_0004] = 32'h0020_0FE1;
    mem[32'h0010_0008] = 32'h0000_0FFE;
    mem[32'h0010_0FFC] = 32'h0030_0001;
    mem[32'h0020_000C] = 32'hABCD_E04F;
    mem[32'h0020_0010] = 32'hFFFF_F07E;
    mem[32'h0030_0FFC] = 32'h1234_507F;
    mem[32'h0020_0000] = 32'h0000_0011;
    mem[32'h0040_0004] = 32'h0050_0001;
    mem[32'h0050_000C] = 32'h7777_7003;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk({31'b0, req_ready},     32'd1, "R1 req_ready");
    chk({31'b0, rsp_valid},     32'd0, "R1 rsp_valid");
    chk({31'b0, mem_req_valid}, 32'd0, "R1 mem_req_valid");

    // R1: root resets to zero, so a walk reads the first entry at 0x4
    lat = 0;
    walk(32'h0040_3456, f, fv, pa, fl, n);
    chk(rlog[0], 32'h0000_0004, "R1 root zero after reset");
    chk({31'b0, f}, 32'd1, "R5 unmapped root yields fault");

    // R11 idle write of root frame 0x00100
    @(negedge clk);
    root_wr_en = 1'b1; root_wr_ppn = 20'h00100;
    @(negedge clk);
    root_wr_en = 1'b0;

    for (int i = 0; i < NV; i++) begin
      lat = int'(VEC[i].lat);
      walk(VEC[i].va, f, fv, pa, fl, n);
      chk({31'b0, f},  {31'b0, VEC[i].flt}, $sformatf("R4 fault flag v%0d", i));
      chk(pa,          VEC[i].pa,           $sformatf("R4 paddr v%0d", i));
      chk({26'b0, fl}, {26'b0, VEC[i].fl},  $sformatf("R4 flags v%0d", i));
      chk(rlog[0],     VEC[i].a1,           $sformatf("R2 first read addr v%0d", i));
      if (VEC[i].flt && !VEC[i].flv) begin
        chk({31'b0, fv}, 32'd0, $sformatf("R5 fault level v%0d", i));
        chk(32'(nlog),   32'd1, $sformatf("R5 read count v%0d", i));
        chk(32'(n), 32'(3 + lat), $sformatf("R8 latency v%0d", i));
      end else begin
        chk(rlog[1], VEC[i].a2, $sformatf("R3 second read addr v%0d", i));
        chk(32'(n), 32'(5 + 2*lat), $sformatf("R8 latency v%0d", i));
        if (VEC[i].flt) begin
          chk({31'b0, fv}, 32'd1, $sformatf("R6 fault level v%0d", i));
          chk(32'(nlog),   32'd2, $sformatf("R6 read count v%0d", i));
        end
      end
      @(negedge clk);
      chk({31'b0, rsp_valid}, 32'd0, $sformatf("R8 single pulse v%0d", i));
    end

    // R10 root write in mid-walk, R9 busy
    lat = 3;
    fork
      walk(32'h0040_3456, f, fv, pa, fl, n);
      begin
        repeat (3) @(negedge clk);
        chk({31'b0, req_ready}, 32'd0, "R9 req_ready low mid-walk");
        root_wr_en = 1'b1; root_wr_ppn = 20'h00400;
        @(negedge clk);
        root_wr_en = 1'b0;
      end
    join
    chk(pa, 32'hABCD_E456, "R10 walk in flight keeps old root");
    chk(rlog[0], 32'h0010_0004, "R10 old root first read");
    lat = 0;
    walk(32'h0040_3456, f, fv, pa, fl, n);
    chk(rlog[0], 32'h0040_0004, "R10 new root first read");
    chk(rlog[1], 32'h0050_000C, "R10 new root second read");
    chk(pa, 32'h7777_7456, "R10 new root paddr");
    chk({26'b0, fl}, 32'h01, "R10 new root flags");

    // R11 idle write restores the first root
    @(negedge clk);
    root_wr_en = 1'b1; root_wr_ppn = 20'h00100;
    @(negedge clk);
    root_wr_en = 1'b0;
    walk(32'h0040_3456, f, fv, pa, fl, n);
    chk(pa, 32'hABCD_E456, "R11 idle root write applied");

    // R7 stalled memory port
    mem_rdy = 1'b0;
    fork
      walk(32'hFFFF_FABC, f, fv, pa, fl, n);
      begin
        repeat (4) @(negedge clk);
        chk({31'b0, mem_req_valid}, 32'd1, "R7 read held during stall");
        chk(mem_req_addr, 32'h0010_0FFC, "R7 address held during stall");
        chk(32'(nlog), 32'd0, "R7 no read issued during stall");
        mem_rdy = 1'b1;
      end
    join
    chk(pa, 32'h1234_5ABC, "R7 result after stall");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule